// File: doc/BRIEF.md
# Read-Triggered Clocked Serial Receiver

This block receives bytes over a clocked serial link in which it owns the serial clock. Software sets the clock divider, the clock idle level and the bit order in a control register, then sets the enable bit. From then on, each access to the data address (a dummy read is enough) launches exactly one eight-bit transfer. The block drives eight clock pulses, samples the data line on each return of the clock to its idle level, and assembles the bits into a holding register that software reads back.

A status register reports a data-ready flag, an overrun flag and a busy flag. Reading the data address hands over the held byte, clears the ready flag and, if reception is still enabled, starts the next byte. Clearing the enable bit before that read collects the last byte without starting another. If a byte completes while the previous one is still unread, the overrun flag is set and the older byte is kept. From that point nothing starts until software writes 0 to the overrun bit.

Top module: `sync_rx_unit`

## Requirements
- R1: After reset the status register (address 1) and the data register (address 2) read 0, and `ser_clk` is low.
- R2: A read or write of address 2 while enable (control bit 0) is 1, overrun is 0 and busy is 0 starts a transfer; busy (status bit 2) reads 1 from the next cycle.
- R3: While enable is 0, a read of address 2 returns the held byte and starts no transfer.
- R4: During a transfer `ser_clk` leaves its idle level (control bit 2) every 2*(div+1) system cycles, where div is control bits 7:4. Each level lasts div+1 cycles. Each transfer has exactly 8 such pulses, and `ser_clk` sits at the idle level whenever busy is 0.
- R5: Control bit 1 = 0 assembles the byte MSB first (the first sampled bit lands in bit 7); control bit 1 = 1 assembles it LSB first.
- R6: On the eighth sample busy clears, ready (status bit 0) sets and the received byte appears at address 2.
- R7: A read of address 2 clears ready.
- R8: An access to address 2 while busy neither restarts nor lengthens the transfer.
- R9: If a byte completes while ready is still 1, overrun (status bit 1) sets, ready stays 1 and address 2 keeps the older byte.
- R10: While overrun is 1 no transfer starts. Writing address 1 with bit 1 = 0 clears overrun; writing bit 1 = 1 leaves it unchanged.
- R11: A write to address 2 starts a transfer like a dummy read does, but leaves ready and the held byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for the addressed register |
| ser_clk | output | 1 | Generated serial clock |
| ser_din | input | 1 | Serial data line |

## Verification
The bench drives the data line from a serial device model that follows the generated clock, so a wrong bit order or a missing or extra clock pulse shows up as a wrong byte or a wrong pulse count. It also reads the data address while a transfer is in flight; a design that restarts on that read would emit more than eight pulses. To reach overrun, it triggers a second byte with a data write while the first byte is still unread. A design that overwrote the held byte, let a transfer start under overrun, or cleared the flag on a write of 1 returns the wrong byte or status. Changing the idle level and the divider between bytes catches a clock that ignores polarity or uses the wrong half period.

// File: rtl/sync_rx_unit.sv
module sync_rx_unit #(
  parameter int W    = 8,
  parameter int DIVW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         ser_clk,
  input  logic         ser_din
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic            en, lsbf, cpol, ready, ovr, busy, act;
  logic [DIVW-1:0] div, cnt;
  logic [CW-1:0]   bits;
  logic [W-1:0]    shr, data_q, next_shr;

  wire data_rd = reg_rd && reg_addr == 2'd2;
  wire data_wr = reg_wr && reg_addr == 2'd2;
  wire start   = (data_rd || data_wr) && en && !ovr && !busy;
  wire tick    = busy && cnt == div;
  wire done    = tick && act && bits == LAST;
  wire held    = ready && !data_rd;

  assign next_shr = lsbf ? {ser_din, shr[W-1:1]} : {shr[W-2:0], ser_din};
  assign ser_clk  = act ^ cpol;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = W'({div, 1'b0, cpol, lsbf, en});
      2'd1:    reg_rdata = W'({busy, ovr, ready});
      2'd2:    reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; lsbf <= 1'b0; cpol <= 1'b0; div <= '0;
      ready <= 1'b0; ovr <= 1'b0; busy <= 1'b0; act <= 1'b0;
      cnt <= '0; bits <= '0; shr <= '0; data_q <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0)
        {div, cpol, lsbf, en} <= {reg_wdata[DIVW+3:4], reg_wdata[2:0]};
      if (reg_wr && reg_addr == 2'd1 && !reg_wdata[1])
        ovr <= 1'b0;

      if (start) begin
        busy <= 1'b1; cnt <= '0; act <= 1'b0; bits <= '0;
      end else if (tick) begin
        cnt <= '0;
        act <= ~act;
        if (act) begin
          shr  <= next_shr;
          bits <= bits + 1'b1;
          if (done) busy <= 1'b0;
        end
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end

      if (done) begin
        if (held) ovr <= 1'b1;
        else begin
          data_q <= next_shr;
          ready  <= 1'b1;
        end
      end else if (data_rd) begin
        ready <= 1'b0;
      end
    end
  end
endmodule

module sync_rx_unit_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   reg_addr,
  input logic         reg_wr,
  input logic         reg_rd,
  input logic         en,
  input logic         cpol,
  input logic         busy,
  input logic         ready,
  input logic         ovr,
  input logic         ser_clk,
  input logic [W-1:0] data_q
);
  wire dacc = (reg_rd || reg_wr) && reg_addr == 2'd2;

  assert_start_by_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(dacc));
  assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en));
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_clk == cpol);
  assert_ready_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $fell(busy));
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd2 && !busy) |=> !ready);
  assert_ovr_keeps_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($stable(data_q) && $fell(busy) && ready));
  assert_no_start_in_ovr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(ovr));
endmodule

bind sync_rx_unit sync_rx_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .en(en), .cpol(cpol), .busy(busy), .ready(ready), .ovr(ovr),
  .ser_clk(ser_clk), .data_q(data_q));

// File: tb/sim_sync_rx_unit.sv
module sim_sync_rx_unit;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ser_clk;
  logic       ser_din = 1'b0;

  sync_rx_unit #(.W(8), .DIVW(4)) u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] tx_q[$];
  logic [7:0] exp_q[$];
  logic cpol_tb = 1'b0, lsb_tb = 1'b0;
  int edges = 0, bitidx = 0;
  time prev_lead = 0, period = 0;
  logic [7:0] cur = '0;

  // serial device model: presents a new bit on each leading clock edge
  always @(ser_clk) begin
    if (rst_n && ser_clk !== cpol_tb) begin
      if (bitidx == 0) cur = (tx_q.size() > 0) ? tx_q.pop_front() : 8'h00;
      ser_din = lsb_tb ? cur[bitidx] : cur[7 - bitidx];
      bitidx = (bitidx + 1) % 8;
      edges++;
      if (prev_lead != 0) period = $time - prev_lead;
      prev_lead = $time;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] b);
    tx_q.push_back(b);
    exp_q.push_back(b);
  endtask

  task automatic read_data(input string req);
    logic [7:0] d, e;
    bus_read(2'd2, d);
    e = exp_q.size() > 0 ? exp_q.pop_front() : 8'hxx;
    check(d === e, req, d, e);
  endtask

  task automatic wait_status(input int bitn, input logic val);
    logic [7:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_read(2'd1, s);
      if (s[bitn] == val) return;
    end
    check(1'b0, "status wait timeout", s, val);
  endtask

  initial begin
    #2000000;
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    bus_read(2'd1, s); check(s == 8'h00, "R1 status", s, 0);
    bus_read(2'd2, d); check(d == 8'h00, "R1 data", d, 0);
    check(ser_clk == 1'b0, "R1 ser_clk", ser_clk, 0);
    // R3: disabled read starts nothing
    bus_read(2'd2, d);
    bus_read(2'd1, s); check(s == 8'h00, "R3 no start when disabled", s, 0);

    // enable, MSB first, div=1, idle low
    bus_write(2'd0, 8'h11);
    expect_byte(8'hA5);
    bus_read(2'd2, d);
    bus_read(2'd1, s); check(s == 8'h04, "R2 busy after dummy read", s, 4);
    wait_status(0, 1'b1);
    bus_read(2'd1, s); check(s == 8'h01, "R6 ready set busy clear", s, 1);
    check(edges == 8, "R4 eight pulses", edges, 8);
    check(period == 40, "R4 period div=1", int'(period), 40);
    expect_byte(8'h3C);
    read_data("R5 MSB first byte");
    bus_read(2'd1, s); check(s == 8'h04, "R7 ready cleared, next started", s, 4);
    bus_read(2'd2, d);
    bus_write(2'd2, 8'h00);
    wait_status(0, 1'b1);
    check(edges == 16, "R8 no restart while busy", edges, 16);

    // LSB first, div=0
    lsb_tb = 1'b1;
    bus_write(2'd0, 8'h03);
    expect_byte(8'h96);
    read_data("R6 held byte");
    wait_status(0, 1'b1);
    check(period == 20, "R4 period div=0", int'(period), 20);

    // idle high
    cpol_tb = 1'b1;
    bus_write(2'd0, 8'h07);
    check(ser_clk == 1'b1, "R4 idle level high", ser_clk, 1);
    expect_byte(8'hE1);
    read_data("R5 LSB first byte");
    wait_status(0, 1'b1);
    check(edges == 32, "R4 pulses with idle high", edges, 32);

    // R3: disable, then collect
    bus_write(2'd0, 8'h06);
    read_data("R3 last byte with idle high");
    bus_read(2'd1, s); check(s == 8'h00, "R3 no new transfer", s, 0);

    // overrun
    cpol_tb = 1'b0; lsb_tb = 1'b0;
    bus_write(2'd0, 8'h01);
    expect_byte(8'h5A);
    bus_read(2'd2, d);
    wait_status(0, 1'b1);
    tx_q.push_back(8'hC3);
    bus_write(2'd2, 8'h00);
    bus_read(2'd1, s); check(s == 8'h05, "R11 write starts, ready kept", s, 5);
    wait_status(2, 1'b0);
    bus_read(2'd1, s); check(s == 8'h03, "R9 overrun set ready kept", s, 3);
    read_data("R9 older byte kept");
    bus_read(2'd1, s); check(s == 8'h02, "R10 no start under overrun", s, 2);
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, s); check(s == 8'h02, "R10 write 1 keeps overrun", s, 2);
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, s); check(s == 8'h00, "R10 write 0 clears overrun", s, 0);
    expect_byte(8'h77);
    bus_read(2'd2, d);
    bus_read(2'd1, s); check(s == 8'h04, "R10 start after clear", s, 4);
    wait_status(0, 1'b1);
    bus_write(2'd0, 8'h00);
    read_data("R7 final byte");
    bus_read(2'd1, s); check(s == 8'h00, "R7 ready cleared at end", s, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule